// File: doc/BRIEF.md
# Double-Buffered Serial Receiver with Parity

This block turns an asynchronous serial line into parallel words for a processor. Each frame begins with a low start bit, carries its payload least significant bit first, and ends with a high stop bit. A shift stage collects the bits of the incoming frame. On the stop bit the completed frame is copied into a separate holding register, which the processor reads. The shift stage can therefore take in the next frame while the previous one waits to be read.

Three payload widths are supported: 7 bits, 8 bits, and 9 bits. In the 7-bit and 8-bit widths, one extra parity bit may follow the data. Parity can be even or odd. The parity check runs on the holding register after the frame has been transferred into it. A receive enable gates the start of new frames. Three sticky error flags report parity mismatches, overruns and bad stop bits. A one-cycle interrupt pulse marks each newly held frame.

The line is sampled on a 16x oversampling tick supplied from outside the block. Reading the data register releases the holding register. Reading the status register clears the error flags.

Top module: `uart_rx_dbuf`

## Requirements
- R1: Frame bits are taken least significant first. Frame bit k appears at `rxData[k]`, and the bits of `rxData` above the frame length read 0.
- R2: The frame length is set by `dataMode`. Value 0 gives 7 bits, value 1 gives 8 bits, and values 2 or 3 give 9 bits. When parity is active, one extra bit is added after the data.
- R3: In the 9-bit widths (`dataMode[1]` = 1), `parityEn` has no effect. No parity bit is expected and `parityErr` never sets.
- R4: With parity active, the parity bit sits at `rxData[7]` in 7-bit mode and at `rxData[8]` in 8-bit mode. With `parityOdd` = 0, `parityErr` sets if the XOR of all held frame bits is 1. With `parityOdd` = 1, it sets if that XOR is 0. The flag is sticky. It sets one cycle after `rxValid` rises.
- R5: Suppose a frame completes while `rxValid` is 1 and `rdData` is not asserted in that cycle. Then `overrunErr` sets, the new frame is discarded, `rxData` is unchanged, and no `rxIrq` is given. A holding register that has already been read never causes an overrun.
- R6: If the stop bit is sampled low, `framingErr` sets. The frame is still delivered to the holding register.
- R7: A start bit is confirmed by sampling the line at the middle of the start bit, 8 ticks after the falling edge is seen. A low pulse shorter than half a bit produces no frame.
- R8: While `rxEnable` is 0, no new frame is started. A frame already in progress when `rxEnable` is cleared still completes and is delivered. Setting `rxEnable` again resumes reception.
- R9: `rxIrq` pulses for exactly one cycle when a frame enters the holding register. A `rdData` strobe clears `rxValid` but leaves the flags alone. A `rdStatus` strobe clears all three error flags.
- R10: After reset, `rxValid`, `rxIrq` and all three error flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| baudTick | input | 1 | One-cycle enable at 16 times the bit rate |
| rxLine | input | 1 | Serial input line, idle high |
| rxEnable | input | 1 | Allows new frames to start |
| dataMode | input | 2 | Payload width: 0 = 7 bits, 1 = 8 bits, 2 or 3 = 9 bits |
| parityEn | input | 1 | Adds and checks a parity bit in the 7-bit and 8-bit widths |
| parityOdd | input | 1 | 1 = odd parity, 0 = even parity |
| rdData | input | 1 | Data register read strobe |
| rdStatus | input | 1 | Status register read strobe |
| rxData | output | 9 | Holding register contents |
| rxValid | output | 1 | Holding register contains an unread frame |
| parityErr | output | 1 | Sticky parity mismatch flag |
| overrunErr | output | 1 | Sticky overrun flag |
| framingErr | output | 1 | Sticky bad stop bit flag |
| rxIrq | output | 1 | One-cycle pulse when a frame is held |

## Verification
Frames are sent with alternating and clustered bit patterns in each payload width. A misplaced bit or a wrong frame length therefore shows up either as a wrong `rxData` or as a false framing error. Parity frames are sent both with the correct parity bit and with it inverted, under both even and odd settings. This separates a correct comparison from an inverted one, and from a parity bit taken from the wrong position. The 9-bit width is run with parity enabled on a word whose parity would fail if it were checked. Separate patterns cover:
- a short low glitch;
- a frame sent with reception disabled;
- a frame interrupted by a disable request;
- a bad stop bit;
- two unread frames back to back.

These patterns distinguish start validation, enable gating and the overrun rule from plain reception.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;
  // Longest frame the shift stage can assemble (data plus optional parity)
  localparam int FRAME_MAX = 9;
  localparam int LEN_W     = $clog2(FRAME_MAX + 1);

  // Strobes from the control FSM to the datapath
  typedef struct packed {
    logic             shiftEn;    // sample the line into the shift stage
    logic             frameDone;  // stop bit sampled this cycle
    logic             stopBad;    // stop bit value was low
    logic [LEN_W-1:0] frameLen;   // bits in the current frame
    logic             parChk;     // parity active for the current frame
    logic             parOdd;     // odd parity selected for the current frame
  } rxStrobes_t;
endpackage

// File: rtl/uart_rx_ctrl.sv
module uart_rx_ctrl
  import uart_rx_pkg::*;
#(
  parameter int OVERSAMPLE = 16
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       baudTick,
  input  logic       rxBit,
  input  logic       rxEnable,
  input  logic [1:0] dataMode,
  input  logic       parityEn,
  input  logic       parityOdd,
  output rxStrobes_t strb
);
  localparam int CW = $clog2(OVERSAMPLE);
  localparam logic [CW-1:0] MID_CNT  = CW'(OVERSAMPLE / 2 - 1);
  localparam logic [CW-1:0] LAST_CNT = CW'(OVERSAMPLE - 1);

  typedef enum logic [1:0] {S_IDLE, S_START, S_DATA, S_STOP} state_e;

  state_e           state;
  logic [CW-1:0]    cnt;
  logic [LEN_W-1:0] bitIdx;
  logic [LEN_W-1:0] lenQ;
  logic             parChkQ;
  logic             parOddQ;

  logic             is9;
  logic             parAct;
  logic [LEN_W-1:0] cfgLen;
  logic             bitEnd;

  // Frame geometry from the configuration; captured when a start is confirmed
  always_comb begin
    is9    = dataMode[1];
    parAct = parityEn && !is9;
    if (is9) cfgLen = LEN_W'(FRAME_MAX);
    else     cfgLen = (dataMode[0] ? LEN_W'(8) : LEN_W'(7)) + LEN_W'(parAct);
  end

  assign bitEnd = baudTick && (cnt == LAST_CNT);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= S_IDLE;
      cnt     <= '0;
      bitIdx  <= '0;
      lenQ    <= LEN_W'(FRAME_MAX);
      parChkQ <= 1'b0;
      parOddQ <= 1'b0;
    end else if (baudTick) begin
      unique case (state)
        S_IDLE: begin
          cnt <= '0;
          if (!rxBit && rxEnable) state <= S_START;
        end
        S_START: begin
          if (cnt == MID_CNT) begin
            cnt <= '0;
            if (!rxBit) begin
              state   <= S_DATA;
              bitIdx  <= '0;
              lenQ    <= cfgLen;
              parChkQ <= parAct;
              parOddQ <= parityOdd;
            end else begin
              state <= S_IDLE;   // too short: glitch
            end
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        S_DATA: begin
          if (cnt == LAST_CNT) begin
            cnt    <= '0;
            bitIdx <= bitIdx + 1'b1;
            if (bitIdx == lenQ - 1'b1) state <= S_STOP;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        S_STOP: begin
          if (cnt == LAST_CNT) begin
            cnt   <= '0;
            state <= S_IDLE;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    strb.shiftEn   = bitEnd && (state == S_DATA);
    strb.frameDone = bitEnd && (state == S_STOP);
    strb.stopBad   = !rxBit;
    strb.frameLen  = lenQ;
    strb.parChk    = parChkQ;
    strb.parOdd    = parOddQ;
  end
endmodule

// File: rtl/uart_rx_dpath.sv
module uart_rx_dpath
  import uart_rx_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 rxLine,
  input  rxStrobes_t           strb,
  input  logic                 rdData,
  input  logic                 rdStatus,
  output logic                 rxBit,
  output logic [FRAME_MAX-1:0] rxData,
  output logic                 rxValid,
  output logic                 parityErr,
  output logic                 overrunErr,
  output logic                 framingErr,
  output logic                 rxIrq
);
  logic [SYNC_STAGES-1:0] syncQ;
  logic [FRAME_MAX-1:0]   shiftQ;
  logic [FRAME_MAX-1:0]   aligned;
  logic [FRAME_MAX-1:0]   holdQ;
  logic                   holdValid;
  logic                   chkPend;
  logic                   chkOdd;
  logic                   load;
  logic                   overrun;
  logic                   parMiss;

  // Line synchronizer
  always_ff @(posedge clk) begin
    if (!rstN) syncQ <= '1;
    else       syncQ <= {syncQ[SYNC_STAGES-2:0], rxLine};
  end
  assign rxBit = syncQ[SYNC_STAGES-1];

  // Shift stage: each new bit enters at the top, so the first bit drifts down
  always_ff @(posedge clk) begin
    if (!rstN)             shiftQ <= '0;
    else if (strb.shiftEn) shiftQ <= {rxBit, shiftQ[FRAME_MAX-1:1]};
  end

  assign aligned = shiftQ >> (LEN_W'(FRAME_MAX) - strb.frameLen);
  assign load    = strb.frameDone && (!holdValid || rdData);
  assign overrun = strb.frameDone && holdValid && !rdData;
  assign parMiss = chkPend && ((^holdQ) != chkOdd);

  // Holding register
  always_ff @(posedge clk) begin
    if (!rstN) begin
      holdQ     <= '0;
      holdValid <= 1'b0;
      rxIrq     <= 1'b0;
      chkPend   <= 1'b0;
      chkOdd    <= 1'b0;
    end else begin
      rxIrq   <= load;
      chkPend <= load && strb.parChk;
      if (load) begin
        holdQ     <= aligned;
        holdValid <= 1'b1;
        chkOdd    <= strb.parOdd;
      end else if (rdData) begin
        holdValid <= 1'b0;
      end
    end
  end

  // Sticky flags: a new event wins over a simultaneous status read
  always_ff @(posedge clk) begin
    if (!rstN) begin
      parityErr  <= 1'b0;
      overrunErr <= 1'b0;
      framingErr <= 1'b0;
    end else begin
      parityErr  <= parMiss || (parityErr && !rdStatus);
      overrunErr <= overrun || (overrunErr && !rdStatus);
      framingErr <= (strb.frameDone && strb.stopBad) || (framingErr && !rdStatus);
    end
  end

  assign rxData  = holdQ;
  assign rxValid = holdValid;
endmodule

// File: rtl/uart_rx_dbuf.sv
module uart_rx_dbuf
  import uart_rx_pkg::*;
#(
  parameter int OVERSAMPLE = 16
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       baudTick,
  input  logic       rxLine,
  input  logic       rxEnable,
  input  logic [1:0] dataMode,
  input  logic       parityEn,
  input  logic       parityOdd,
  input  logic       rdData,
  input  logic       rdStatus,
  output logic [8:0] rxData,
  output logic       rxValid,
  output logic       parityErr,
  output logic       overrunErr,
  output logic       framingErr,
  output logic       rxIrq
);
  rxStrobes_t strb;
  logic       rxBit;

  uart_rx_ctrl #(.OVERSAMPLE(OVERSAMPLE)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .baudTick  (baudTick),
    .rxBit     (rxBit),
    .rxEnable  (rxEnable),
    .dataMode  (dataMode),
    .parityEn  (parityEn),
    .parityOdd (parityOdd),
    .strb      (strb)
  );

  uart_rx_dpath #(.SYNC_STAGES(2)) u_dpath (
    .clk        (clk),
    .rstN       (rstN),
    .rxLine     (rxLine),
    .strb       (strb),
    .rdData     (rdData),
    .rdStatus   (rdStatus),
    .rxBit      (rxBit),
    .rxData     (rxData),
    .rxValid    (rxValid),
    .parityErr  (parityErr),
    .overrunErr (overrunErr),
    .framingErr (framingErr),
    .rxIrq      (rxIrq)
  );
endmodule

// File: rtl/uart_rx_chk.sv
module uart_rx_chk (
  input logic       clk,
  input logic       rstN,
  input logic       rdData,
  input logic       rdStatus,
  input logic [8:0] rxData,
  input logic       rxValid,
  input logic       parityErr,
  input logic       overrunErr,
  input logic       framingErr,
  input logic       rxIrq
);
  assert_irq_single_R9: assert property (@(posedge clk) disable iff (!rstN)
    rxIrq |=> !rxIrq);

  assert_irq_with_valid_R9: assert property (@(posedge clk) disable iff (!rstN)
    rxIrq |-> rxValid);

  assert_read_clears_R9: assert property (@(posedge clk) disable iff (!rstN)
    rdData |=> (!rxValid || rxIrq));

  assert_hold_kept_R5: assert property (@(posedge clk) disable iff (!rstN)
    (rxValid && !rdData) |=> (rxValid && $stable(rxData)));

  assert_parity_sticky_R4: assert property (@(posedge clk) disable iff (!rstN)
    (parityErr && !rdStatus) |=> parityErr);

  assert_overrun_sticky_R5: assert property (@(posedge clk) disable iff (!rstN)
    (overrunErr && !rdStatus) |=> overrunErr);

  assert_framing_sticky_R6: assert property (@(posedge clk) disable iff (!rstN)
    (framingErr && !rdStatus) |=> framingErr);
endmodule

bind uart_rx_dbuf uart_rx_chk u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .rdData     (rdData),
  .rdStatus   (rdStatus),
  .rxData     (rxData),
  .rxValid    (rxValid),
  .parityErr  (parityErr),
  .overrunErr (overrunErr),
  .framingErr (framingErr),
  .rxIrq      (rxIrq)
);

// File: tb/tb_uart_rx_dbuf.sv
module tb_uart_rx_dbuf;
  localparam int CLK_PERIOD = 10;
  localparam int TICK_DIV   = 2;
  localparam int BIT_CLKS   = 16 * TICK_DIV;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       baudTick = 1'b0;
  logic       rxLine = 1'b1;
  logic       rxEnable = 1'b0;
  logic [1:0] dataMode = 2'd1;
  logic       parityEn = 1'b0;
  logic       parityOdd = 1'b0;
  logic       rdData = 1'b0;
  logic       rdStatus = 1'b0;
  logic [8:0] rxData;
  logic       rxValid, parityErr, overrunErr, framingErr, rxIrq;

  uart_rx_dbuf dut (
    .clk(clk), .rstN(rstN), .baudTick(baudTick), .rxLine(rxLine),
    .rxEnable(rxEnable), .dataMode(dataMode), .parityEn(parityEn),
    .parityOdd(parityOdd), .rdData(rdData), .rdStatus(rdStatus),
    .rxData(rxData), .rxValid(rxValid), .parityErr(parityErr),
    .overrunErr(overrunErr), .framingErr(framingErr), .rxIrq(rxIrq)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  int tickCnt = 0;
  always @(negedge clk) begin
    tickCnt  <= (tickCnt == TICK_DIV - 1) ? 0 : tickCnt + 1;
    baudTick <= (tickCnt == TICK_DIV - 1);
  end

  int irqCount = 0;
  always @(posedge clk) if (rstN && rxIrq) irqCount <= irqCount + 1;

  typedef struct {
    logic [8:0] data;
    logic       pErr;
    logic       fErr;
    string      req;
  } exp_t;
  exp_t expQ[$];

  int checks = 0;
  int errors = 0;
  bit autoRead = 1'b1;

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic driveBit(input logic v, input int clks);
    rxLine = v;
    repeat (clks) @(negedge clk);
  endtask

  // Build and send one frame; optionally push the expected holding value
  task automatic sendFrame(input int width, input logic pe, input logic odd,
                           input logic [8:0] d, input logic flip,
                           input logic stopOk, input logic push, input string req);
    logic [9:0] bits;
    logic       p;
    logic       parAct;
    int         n;
    exp_t       e;
    @(negedge clk);
    dataMode  = (width == 7) ? 2'd0 : (width == 8) ? 2'd1 : 2'd2;
    parityEn  = pe;
    parityOdd = odd;
    parAct    = pe && (width != 9);
    bits      = '0;
    for (int i = 0; i < width; i++) bits[i] = d[i];
    n = width;
    if (parAct) begin
      p = ^bits;
      if (odd)  p = ~p;
      if (flip) p = ~p;
      bits[width] = p;
      n = width + 1;
    end
    if (push) begin
      e.data = bits[8:0];
      e.pErr = parAct && flip;
      e.fErr = !stopOk;
      e.req  = req;
      expQ.push_back(e);
    end
    driveBit(1'b0, BIT_CLKS);
    for (int i = 0; i < n; i++) driveBit(bits[i], BIT_CLKS);
    if (stopOk) driveBit(1'b1, BIT_CLKS);
    else        driveBit(1'b0, 24);
    driveBit(1'b1, 2 * BIT_CLKS);
  endtask

  // Monitor: on each interrupt, compare the held frame with the scoreboard
  initial begin
    forever begin
      @(negedge clk);
      if (rstN && rxIrq && autoRead) begin
        exp_t e;
        repeat (2) @(negedge clk);
        if (expQ.size() == 0) begin
          checks++;
          errors++;
          $display("FAIL R8 unexpected frame: actual=%0h expected=none", rxData);
        end else begin
          e = expQ.pop_front();
          chk(e.req, "data", 32'(rxData), 32'(e.data));
          chk("R9", "valid before read", 32'(rxValid), 32'd1);
          chk(e.pErr ? "R4" : e.req, "parityErr", 32'(parityErr), 32'(e.pErr));
          chk(e.fErr ? "R6" : e.req, "framingErr", 32'(framingErr), 32'(e.fErr));
          chk("R5", "overrunErr", 32'(overrunErr), 32'd0);
        end
        rdData   = 1'b1;
        rdStatus = 1'b1;
        @(negedge clk);
        rdData   = 1'b0;
        rdStatus = 1'b0;
        chk("R9", "valid after read", 32'(rxValid), 32'd0);
        chk("R9", "flags after status read",
            32'({parityErr, overrunErr, framingErr}), 32'd0);
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int c0;
    repeat (4) @(negedge clk);
    // R10: state under reset
    chk("R10", "rxValid", 32'(rxValid), 32'd0);
    chk("R10", "rxIrq", 32'(rxIrq), 32'd0);
    chk("R10", "flags", 32'({parityErr, overrunErr, framingErr}), 32'd0);
    rstN = 1'b1;
    rxEnable = 1'b1;
    repeat (BIT_CLKS) @(negedge clk);

    // R1, R2: plain frames in each width
    sendFrame(8, 1'b0, 1'b0, 9'h0A5, 1'b0, 1'b1, 1'b1, "R1");
    sendFrame(8, 1'b0, 1'b0, 9'h03C, 1'b0, 1'b1, 1'b1, "R1");
    sendFrame(7, 1'b0, 1'b0, 9'h055, 1'b0, 1'b1, 1'b1, "R2");
    sendFrame(9, 1'b0, 1'b0, 9'h1C3, 1'b0, 1'b1, 1'b1, "R2");

    // R4: parity both senses, right and wrong, in both widths
    sendFrame(8, 1'b1, 1'b0, 9'h096, 1'b0, 1'b1, 1'b1, "R4");
    sendFrame(8, 1'b1, 1'b0, 9'h096, 1'b1, 1'b1, 1'b1, "R4");
    sendFrame(8, 1'b1, 1'b1, 9'h013, 1'b0, 1'b1, 1'b1, "R4");
    sendFrame(8, 1'b1, 1'b1, 9'h013, 1'b1, 1'b1, 1'b1, "R4");
    sendFrame(7, 1'b1, 1'b0, 9'h02B, 1'b0, 1'b1, 1'b1, "R4");
    sendFrame(7, 1'b1, 1'b1, 9'h02B, 1'b1, 1'b1, 1'b1, "R4");

    // R3: parity enable ignored in 9-bit width (odd check would fail here)
    sendFrame(9, 1'b1, 1'b1, 9'h0FF, 1'b0, 1'b1, 1'b1, "R3");

    // R6: stop bit low
    sendFrame(8, 1'b0, 1'b0, 9'h05A, 1'b0, 1'b0, 1'b1, "R6");

    // R7: short low glitch gives no frame
    c0 = irqCount;
    @(negedge clk);
    driveBit(1'b0, 8);
    driveBit(1'b1, 12 * BIT_CLKS);
    chk("R7", "irq count after glitch", 32'(irqCount), 32'(c0));
    chk("R7", "rxValid after glitch", 32'(rxValid), 32'd0);

    // R8: disabled reception ignores a frame
    rxEnable = 1'b0;
    c0 = irqCount;
    sendFrame(8, 1'b0, 1'b0, 9'h0C7, 1'b0, 1'b1, 1'b0, "R8");
    chk("R8", "irq count while disabled", 32'(irqCount), 32'(c0));
    chk("R8", "rxValid while disabled", 32'(rxValid), 32'd0);

    // R8: clearing enable mid-frame lets the frame finish
    rxEnable = 1'b1;
    fork
      sendFrame(8, 1'b0, 1'b0, 9'h0E1, 1'b0, 1'b1, 1'b1, "R8");
      begin
        repeat (4 * BIT_CLKS) @(negedge clk);
        rxEnable = 1'b0;
      end
    join
    chk("R8", "frame finished after disable", 32'(expQ.size()), 32'd0);
    c0 = irqCount;
    sendFrame(8, 1'b0, 1'b0, 9'h0F0, 1'b0, 1'b1, 1'b0, "R8");
    chk("R8", "stays off after mid-frame disable", 32'(irqCount), 32'(c0));
    rxEnable = 1'b1;
    sendFrame(8, 1'b0, 1'b0, 9'h081, 1'b0, 1'b1, 1'b1, "R8");

    // R5: two unread frames
    autoRead = 1'b0;
    c0 = irqCount;
    sendFrame(8, 1'b0, 1'b0, 9'h011, 1'b0, 1'b1, 1'b0, "R5");
    sendFrame(8, 1'b0, 1'b0, 9'h022, 1'b0, 1'b1, 1'b0, "R5");
    chk("R5", "first frame kept", 32'(rxData), 32'h011);
    chk("R5", "overrunErr", 32'(overrunErr), 32'd1);
    chk("R5", "single interrupt", 32'(irqCount), 32'(c0 + 1));
    chk("R5", "rxValid", 32'(rxValid), 32'd1);
    rdData = 1'b1;
    @(negedge clk);
    rdData = 1'b0;
    chk("R9", "data read clears valid", 32'(rxValid), 32'd0);
    chk("R9", "data read keeps flag", 32'(overrunErr), 32'd1);
    rdStatus = 1'b1;
    @(negedge clk);
    rdStatus = 1'b0;
    chk("R9", "status read clears overrun", 32'(overrunErr), 32'd0);
    autoRead = 1'b1;

    // R5: read holding register, then next frame causes no overrun
    sendFrame(8, 1'b0, 1'b0, 9'h0B4, 1'b0, 1'b1, 1'b1, "R5");
    sendFrame(7, 1'b0, 1'b0, 9'h04E, 1'b0, 1'b1, 1'b1, "R1");

    repeat (BIT_CLKS) @(negedge clk);
    chk("R9", "all expected frames seen", 32'(expQ.size()), 32'd0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule